// File: doc/BRIEF.md
# I2C GPIO Expander Target

This block is an I2C target that exposes a bank of general-purpose pins through four groups of byte-wide registers. The groups are a live input view, the output levels, a per-pin polarity inversion, and a per-pin direction. The pins come in banks of eight, and the build supports one to four banks. A controller addresses the device by its 7-bit strapped address and writes one pointer byte. It then either writes data bytes in the same transaction, or issues a repeated start and reads bytes back. A run of bytes moves through the consecutive banks of one group and wraps back to bank 0 of that group.

The bus lines are sampled with the system clock. SCL and SDA pass through a two-flop synchronizer, and an edge detector turns them into start, stop and clock-edge events. The design drives SDA only through an open-drain enable. Each pin has an output level and a driver enable. Each pin also has a synchronized input sample that the input group reads.

Top module: `gpx_i2c_target`

## Requirements
- R1: The device acknowledges an address byte whose upper seven bits equal `dev_addr`. For any other address it leaves SDA released for the whole transaction.
- R2: The pointer byte is decoded as follows: bits [3:2] select the group (00 input, 01 output, 10 polarity, 11 direction) and bits [1:0] select the bank. A pointer whose bits [7:4] are not zero, or whose bank is not below BANKS, is NACKed and the stored pointer stays as it was.
- R3: Each data byte written is stored into the register at the pointer. The pointer then advances to the next bank of the same group, and from the last bank it wraps to bank 0.
- R4: After a repeated start with the read bit set, the device returns the register at the pointer for every byte. The pointer advances the same way as in R3, and a read without a new pointer byte continues from the stored pointer.
- R5: A direction bit of 1 makes the pin an input (`pin_oe` low). A direction bit of 0 makes it an output, with `pin_oe` high and `pin_o` equal to its output bit. `pin_oe` changes only as the result of a written byte.
- R6: A read of the input group returns the live synchronized pin level of every pin. The level is inverted only where the polarity bit is 1 and the pin is an input. Output pins are never inverted.
- R7: Writes to the input group are acknowledged and change no state. `pin_o` and `pin_oe` stay unchanged, and a later input read still shows the pin levels.
- R8: After reset, every pin is an input, every output bit is 1, every polarity bit is 0, and SDA is released.
- R9: An output value written while a pin is an input appears on `pin_o` at once. It is driven as soon as the pin is switched to output.
- R10: The input byte is captured when its transfer begins. A pin change during the shifting of that byte does not alter it, but the next byte of the same read sees the new level.
- R11: SDA drive changes only while the synchronized SCL is low. A stop condition releases SDA on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_addr | input | 7 | Strapped 7-bit target address |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| pin_i | input | 8*BANKS | Pin levels seen at the pads |
| pin_o | output | 8*BANKS | Output levels from the output group |
| pin_oe | output | 8*BANKS | Output driver enable per pin |

## Verification
Two functions can fall in the same cycle here: the capture of input pins into the read shift register, and a pin change on `pin_i`. The bench provokes this by changing every pin level in the middle of the first byte of a two-byte input read. The first byte must hold the old, inverted-as-configured value and the second must hold the new one, which fixes the capture instant at the start of each byte. Banks with mixed directions and polarity bits set on output pins check that inversion follows the direction bit. Writes to the input group are judged by watching the pin outputs and then reading back.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [1:0] {
    GRP_IN  = 2'd0,
    GRP_OUT = 2'd1,
    GRP_POL = 2'd2,
    GRP_DIR = 2'd3
  } grp_e;

  typedef struct packed {
    grp_e       grp;
    logic [1:0] bank;
  } ptr_t;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_PTR,
    LK_PACK,
    LK_WR,
    LK_WACK,
    LK_RD,
    LK_RACK
  } link_st_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      q      <= RST;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter int BANKS = 2,
  localparam int NP = 8 * BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  ptr_t          wr_ptr,
  input  logic [7:0]    wr_data,
  input  ptr_t          rd_ptr,
  input  logic [NP-1:0] pin_s,
  output logic [7:0]    rd_data,
  output logic [NP-1:0] out_v,
  output logic [NP-1:0] pol_v,
  output logic [NP-1:0] dir_v
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [7:0] out_q, pol_q, dir_q;
    logic [7:0] out_d, pol_d, dir_d;
    logic       bank_we;

    assign bank_we = wr_en && (wr_ptr.bank == 2'(b));

    always_comb begin
      out_d = out_q;
      pol_d = pol_q;
      dir_d = dir_q;
      if (bank_we) begin
        case (wr_ptr.grp)
          GRP_OUT: out_d = wr_data;
          GRP_POL: pol_d = wr_data;
          GRP_DIR: dir_d = wr_data;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= 8'hFF;
        pol_q <= 8'h00;
        dir_q <= 8'hFF;
      end else if (bank_we) begin
        out_q <= out_d;
        pol_q <= pol_d;
        dir_q <= dir_d;
      end
    end

    assign out_v[b*8 +: 8] = out_q;
    assign pol_v[b*8 +: 8] = pol_q;
    assign dir_v[b*8 +: 8] = dir_q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < BANKS; b++) begin
      if (rd_ptr.bank == 2'(b)) begin
        case (rd_ptr.grp)
          GRP_IN:  rd_data = pin_s[b*8 +: 8] ^ (pol_v[b*8 +: 8] & dir_v[b*8 +: 8]);
          GRP_OUT: rd_data = out_v[b*8 +: 8];
          GRP_POL: rd_data = pol_v[b*8 +: 8];
          default: rd_data = dir_v[b*8 +: 8];
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_link.sv
module gpx_link
  import gpx_pkg::*;
#(
  parameter int BANKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  output ptr_t       ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       start,
  output logic       stop,
  output logic       sda_oe
);
  localparam logic [2:0] LAST_BANK = 3'(BANKS - 1);

  link_st_e   st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       rw_q, rw_d;
  logic       mack_q, mack_d;
  logic       oe_q, oe_d;
  ptr_t       ptr_q, ptr_d;
  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall, ptr_ok;

  function automatic ptr_t step(ptr_t p);
    ptr_t n = p;
    n.bank = ({1'b0, p.bank} == LAST_BANK) ? 2'd0 : p.bank + 2'd1;
    return n;
  endfunction

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign ptr_ok   = (sh_q[7:4] == 4'h0) && ({1'b0, sh_q[1:0]} <= LAST_BANK);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rw_d = rw_q;
    mack_d = mack_q; oe_d = oe_q; ptr_d = ptr_q; wr_en = 1'b0;
    if (start) begin
      st_d = LK_ADDR; cnt_d = 4'd0; oe_d = 1'b0;
    end else if (stop) begin
      st_d = LK_IDLE; oe_d = 1'b0;
    end else if (scl_rise) begin
      if ((st_q == LK_ADDR || st_q == LK_PTR || st_q == LK_WR) && cnt_q != 4'd8) begin
        sh_d  = {sh_q[6:0], sda_s};
        cnt_d = cnt_q + 4'd1;
      end else if (st_q == LK_RACK) begin
        mack_d = ~sda_s;
      end
    end else if (scl_fall) begin
      case (st_q)
        LK_ADDR: if (cnt_q == 4'd8) begin
          if (sh_q[7:1] == dev_addr) begin
            st_d = LK_AACK; oe_d = 1'b1; rw_d = sh_q[0];
          end else st_d = LK_IDLE;
        end
        LK_PTR: if (cnt_q == 4'd8) begin
          if (ptr_ok) begin
            st_d = LK_PACK; oe_d = 1'b1; ptr_d = ptr_t'(sh_q[3:0]);
          end else st_d = LK_IDLE;
        end
        LK_WR: if (cnt_q == 4'd8) begin
          wr_en = 1'b1; ptr_d = step(ptr_q); st_d = LK_WACK; oe_d = 1'b1;
        end
        LK_AACK, LK_RACK: begin
          cnt_d = 4'd0;
          if (st_q == LK_AACK && !rw_q) begin
            st_d = LK_PTR; oe_d = 1'b0;
          end else if (st_q == LK_RACK && !mack_q) begin
            st_d = LK_IDLE; oe_d = 1'b0;
          end else begin
            st_d = LK_RD; sh_d = rd_data; oe_d = ~rd_data[7]; ptr_d = step(ptr_q);
          end
        end
        LK_PACK, LK_WACK: begin
          st_d = LK_WR; oe_d = 1'b0; cnt_d = 4'd0;
        end
        LK_RD: if (cnt_q == 4'd7) begin
          st_d = LK_RACK; oe_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 4'd1; sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_IDLE; cnt_q <= 4'd0; sh_q <= 8'h00; rw_q <= 1'b0;
      mack_q <= 1'b0; oe_q <= 1'b0; ptr_q <= '0; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rw_q <= rw_d;
      mack_q <= mack_d; oe_q <= oe_d; ptr_q <= ptr_d; scl_q <= scl_s; sda_q <= sda_s;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter int BANKS = 2,
  localparam int NP = 8 * BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dev_addr,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] pin_o,
  output logic [NP-1:0] pin_oe
);
  logic [1:0]    rst_sh;
  logic          rst_q;
  logic [1:0]    bus_s;
  logic          scl_s, sda_s;
  logic [NP-1:0] pin_s, pol_v, dir_v;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en, start, stop;
  ptr_t          ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q = rst_sh[1];

  gpx_sync #(.W(2), .RST(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_q), .d({scl_i, sda_i}), .q(bus_s));
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  gpx_sync #(.W(NP), .RST('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_q), .d(pin_i), .q(pin_s));

  gpx_link #(.BANKS(BANKS)) u_link (
    .clk(clk), .rst_n(rst_q), .dev_addr(dev_addr), .scl_s(scl_s), .sda_s(sda_s),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .start(start), .stop(stop), .sda_oe(sda_oe));

  gpx_regbank #(.BANKS(BANKS)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_ptr(ptr), .wr_data(wr_data),
    .rd_ptr(ptr), .pin_s(pin_s), .rd_data(rd_data), .out_v(pin_o),
    .pol_v(pol_v), .dir_v(dir_v));

  assign pin_oe = ~dir_v;
endmodule

// File: rtl/gpx_i2c_target_chk.sv
module gpx_i2c_target_chk #(
  parameter int BANKS = 2,
  localparam int NP = 8 * BANKS
) (
  input logic          clk,
  input logic          rst_q,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          stop,
  input logic          wr_en,
  input logic [3:0]    ptr,
  input logic [NP-1:0] pin_o,
  input logic [NP-1:0] pin_oe
);
  p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(sda_oe) |-> !scl_s);

  p_stop_releases_r11: assert property (@(posedge clk) disable iff (!rst_q)
    stop |=> !sda_oe);

  p_dir_by_write_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(pin_oe) |-> $past(wr_en));

  p_out_by_write_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(pin_o) |-> ($past(wr_en) && $past(ptr[3:2]) == 2'd1));

  p_input_write_void_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && ptr[3:2] == 2'd0) |=> ($stable(pin_o) && $stable(pin_oe)));

  p_ptr_bank_legal_r2: assert property (@(posedge clk) disable iff (!rst_q)
    {1'b0, ptr[1:0]} < 3'(BANKS));
endmodule

bind gpx_i2c_target gpx_i2c_target_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst_q(rst_q), .scl_s(scl_s), .sda_oe(sda_oe), .stop(stop),
  .wr_en(wr_en), .ptr(ptr), .pin_o(pin_o), .pin_oe(pin_oe));

// File: tb/gpx_i2c_target_tb.sv
module gpx_i2c_target_tb;
  localparam int         BANKS = 2;
  localparam int         NP    = 8 * BANKS;
  localparam int         Q     = 8;
  localparam logic [6:0] ADDR  = 7'h21;

  // {pointer, data}: written, then read back expecting data
  localparam logic [15:0] VEC [6] = '{
    16'h04A5, 16'h053C, 16'h080F, 16'h0DF0, 16'h0C00, 16'h0981
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [NP-1:0] pin_drv = '0;
  logic sda_oe;
  logic [NP-1:0] pin_o, pin_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic ok;

  always #4 clk = ~clk;

  gpx_i2c_target #(.BANKS(BANKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .pin_i(pin_drv), .pin_o(pin_o), .pin_oe(pin_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    scl_m = 1'b0; hold(Q); sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q); sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    scl_m = 1'b0; sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q); scl_m = 1'b1; hold(2 * Q); scl_m = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    ack = ~sda_bus; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl_m = 1'b1; hold(Q); b[i] = sda_bus; hold(Q); scl_m = 1'b0; hold(Q);
    end
    sda_m = ~give_ack; hold(Q); scl_m = 1'b1; hold(2 * Q); scl_m = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_regs(input logic [7:0] p, input int n, output logic allack);
    logic a;
    i2c_start(); wbyte({ADDR, 1'b0}, a); allack = a;
    wbyte(p, a); allack &= a;
    for (int i = 0; i < n; i++) begin wbyte(wbuf[i], a); allack &= a; end
    i2c_stop();
  endtask

  task automatic rd_regs(input logic [7:0] p, input int n, output logic allack);
    logic a;
    i2c_start(); wbyte({ADDR, 1'b0}, a); allack = a;
    wbyte(p, a); allack &= a;
    i2c_start(); wbyte({ADDR, 1'b1}, a); allack &= a;
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    hold(5); rst_n = 1'b1; hold(5);

    // R8 reset state
    chk("R8 pin_oe", 32'(pin_oe), 32'h0);
    chk("R8 pin_o", 32'(pin_o), 32'hFFFF);
    chk("R8 sda_oe", 32'(sda_oe), 32'h0);
    rd_regs(8'h0C, 2, ok);
    chk("R8 dir read", {16'h0, rbuf[1], rbuf[0]}, 32'hFFFF);
    rd_regs(8'h08, 2, ok);
    chk("R8 pol read", {16'h0, rbuf[1], rbuf[0]}, 32'h0000);

    // R1 foreign address
    i2c_start(); wbyte({7'h22, 1'b0}, a); wbyte(8'h04, ok); i2c_stop();
    chk("R1 foreign addr nack", 32'(a), 32'h0);
    chk("R1 foreign addr no drive", 32'(ok), 32'h0);
    chk("R1 foreign addr no write", 32'(pin_o), 32'hFFFF);

    // R3/R4 vector table
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][7:0];
      wr_regs(VEC[v][15:8], 1, ok);
      chk("R1 R3 write acked", 32'(ok), 32'h1);
      rd_regs(VEC[v][15:8], 1, ok);
      chk("R4 readback", 32'(rbuf[0]), 32'(VEC[v][7:0]));
    end
    chk("R5 pin_oe mixed", 32'(pin_oe), 32'h0FFF);
    chk("R5 pin_o", 32'(pin_o), 32'h3CA5);

    // R3 multi-byte write with wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_regs(8'h04, 3, ok);
    chk("R3 wrap write", 32'(pin_o), 32'h2233);
    rd_regs(8'h05, 3, ok);
    chk("R4 wrap read", {8'h0, rbuf[0], rbuf[1], rbuf[2]}, 32'h223322);

    // R2 pointer validity
    wr_regs(8'h0C, 0, ok);
    chk("R2 valid ptr", 32'(ok), 32'h1);
    wr_regs(8'h06, 0, ok);
    chk("R2 bank out of range nack", 32'(ok), 32'h0);
    wr_regs(8'h14, 0, ok);
    chk("R2 upper bits nack", 32'(ok), 32'h0);
    i2c_start(); wbyte({ADDR, 1'b1}, a); rbyte(1'b0, rbuf[0]); i2c_stop();
    chk("R2 R4 pointer kept", 32'(rbuf[0]), 32'h00);

    // R9 preload then enable
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wr_regs(8'h0C, 2, ok);
    wbuf[0] = 8'h5A; wbuf[1] = 8'h66; wr_regs(8'h04, 2, ok);
    chk("R9 preload not driven", 32'(pin_oe), 32'h0);
    chk("R9 preload level", 32'(pin_o), 32'h665A);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wr_regs(8'h0C, 2, ok);
    chk("R9 R5 driven", 32'(pin_oe), 32'hFFFF);
    chk("R9 preload kept", 32'(pin_o), 32'h665A);

    // R6 inversion only on inputs
    wbuf[0] = 8'h0F; wbuf[1] = 8'hF0; wr_regs(8'h0C, 2, ok);
    pin_drv = 16'hC33C; hold(4);
    rd_regs(8'h00, 2, ok);
    chk("R6 input bank0", 32'(rbuf[0]), 32'h33);
    chk("R6 input bank1", 32'(rbuf[1]), 32'h43);

    // R7 input group write ignored
    wbuf[0] = 8'h55; wr_regs(8'h00, 1, ok);
    chk("R7 write acked", 32'(ok), 32'h1);
    chk("R7 pin_o kept", 32'(pin_o), 32'h665A);
    chk("R7 pin_oe kept", 32'(pin_oe), 32'h0FF0);
    rd_regs(8'h00, 1, ok);
    chk("R7 input still live", 32'(rbuf[0]), 32'h33);

    // R10 capture at byte start while pins change mid-byte
    i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(8'h00, a);
    i2c_start(); wbyte({ADDR, 1'b1}, a);
    fork
      begin rbyte(1'b1, rbuf[0]); rbyte(1'b0, rbuf[1]); end
      begin hold(12 * Q); pin_drv = 16'h5AA5; end
    join
    i2c_stop();
    chk("R10 first byte old", 32'(rbuf[0]), 32'h33);
    chk("R10 second byte new", 32'(rbuf[1]), 32'hDA);

    // R11 released after stop
    hold(2);
    chk("R11 sda released", 32'(sda_oe), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule